// File: doc/BRIEF.md
# Time-Slot Integration Sequencer

This block produces the timing that lines up the averaging windows of a gain-control loop with the time slots of the system. A slot counter runs through a programmable slot period. At every slot start the sequencer waits a programmable offset. It then runs a programmable number of integration windows back to back, each of a programmable length. After the last window it stays quiet until the next slot begins. The gain loop receives three signals: a level that is high while samples are to be accumulated, a pulse on the first sample of each window, and a pulse on the last sample of each window.

An external sync input can realign the slot counter to system timing when it is enabled. A sync cancels any window in progress and restarts the offset phase. A slot boundary that arrives before the windows finish has the same effect. Every configuration value of zero is treated as one, so no counter can stall.

Top module: `tsis_sequencer`

## Requirements
- R1: With slot period S (zero meaning one), `slot_start` is high in exactly one cycle out of every S. The first cycle after reset is position 0 of a slot, where `slot_start` is high.
- R2: When `sync_en` and `sync_in` are both high in a cycle, the next cycle is position 0 of a new slot. `sync_in` has no effect while `sync_en` is low.
- R3: With start offset D (zero meaning one), the first window of a slot starts at position D, counted from position 0.
- R4: Each window lasts L cycles (zero meaning one), and `integ_active` is high throughout it. `integ_start` is high only in the window's first cycle, and `integ_done` is high only in its last cycle.
- R5: A slot holds up to N windows (zero meaning one). They follow each other with no gap, so each window starts in the cycle after the previous one is done.
- R6: After the N-th window is done, `integ_active`, `integ_start` and `integ_done` stay low until the slot ends.
- R7: A sync that is taken cancels the running window. In the following cycle `integ_active` is low, and the offset of R3 begins again from position 0.
- R8: A slot boundary cuts short any window still running. `integ_done` is not raised for a window that is cut short.
- R9: While reset is held, `integ_active`, `integ_start` and `integ_done` are low and `slot_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | Lets `sync_in` realign the slot counter |
| sync_in | input | 1 | External slot alignment pulse |
| slot_len | input | CNT_W | Slot period in cycles (0 is taken as 1) |
| start_dly | input | CNT_W | Offset from slot start to the first window (0 is taken as 1) |
| integ_len | input | CNT_W | Window length in cycles (0 is taken as 1) |
| integ_count | input | NUM_W | Windows per slot (0 is taken as 1) |
| slot_start | output | 1 | High at position 0 of each slot |
| integ_active | output | 1 | High while a window is open |
| integ_start | output | 1 | High on the first cycle of a window |
| integ_done | output | 1 | High on the last cycle of a completed window |

## Verification
The assertions check on every cycle that a wrap or sync returns the slot to position 0 and clears the window, that the offset hands over to a window start, and that windows follow each other without a gap. They also check that the sequencer falls silent after the last window. Only the bench scenarios can show the absolute positions. These include the exact offset and window lengths for each setting, truncation at a slot boundary, clamping of zero values, and the fact that a sync is ignored while it is disabled. The bench compares every output against a position-based model over several slots.

// File: rtl/tsis_pkg.sv
package tsis_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_INTEG = 2'd2
    } phase_e;
endpackage

// File: rtl/tsis_last_idx.sv
module tsis_last_idx #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] last
);
    // A programmed zero behaves as one: last index 0.
    always_comb begin
        if (val == '0) last = '0;
        else           last = val - W'(1);
    end
endmodule

// File: rtl/tsis_slot_timer.sv
module tsis_slot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] slot_last,
    output logic             slot_start,
    output logic             slot_wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } tmr_t;

    tmr_t st_d, st_q;
    logic sync_take;

    always_comb begin
        st_d      = st_q;
        sync_take = sync_en && sync_in;
        slot_wrap = sync_take || (st_q.pos >= slot_last);
        if (slot_wrap) st_d.pos = '0;
        else           st_d.pos = st_q.pos + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_start = (st_q.pos == '0);

    // R1: a wrap always lands on position 0
    p_wrap_to_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wrap |=> slot_start);

    // R1: position never passes the last index while the period is steady
    p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(slot_last) |-> (st_q.pos <= slot_last));

    // R2: an accepted sync realigns the slot
    p_sync_realign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && sync_in) |=> slot_start);
endmodule

// File: rtl/tsis_integ_seq.sv
module tsis_integ_seq
    import tsis_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_wrap,
    input  logic [CNT_W-1:0] dly_last,
    input  logic [CNT_W-1:0] len_last,
    input  logic [NUM_W-1:0] num_last,
    output logic             integ_active,
    output logic             integ_start,
    output logic             integ_done
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] dly;
        logic [CNT_W-1:0] len;
        logic [NUM_W-1:0] num;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_DELAY, dly: '0, len: '0, num: '0};

    seq_t st_d, st_q;
    logic len_end, num_end;

    always_comb begin
        st_d    = st_q;
        len_end = (st_q.len >= len_last);
        num_end = (st_q.num >= num_last);
        if (slot_wrap) begin
            st_d = SEQ_RST;
        end else begin
            unique case (st_q.ph)
                PH_DELAY: begin
                    if (st_q.dly >= dly_last) begin
                        st_d.ph  = PH_INTEG;
                        st_d.len = '0;
                        st_d.num = '0;
                    end else begin
                        st_d.dly = st_q.dly + CNT_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (len_end) begin
                        st_d.len = '0;
                        if (num_end) st_d.ph  = PH_IDLE;
                        else         st_d.num = st_q.num + NUM_W'(1);
                    end else begin
                        st_d.len = st_q.len + CNT_W'(1);
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        integ_active = (st_q.ph == PH_INTEG);
        integ_start  = integ_active && (st_q.len == '0);
        integ_done   = integ_active && len_end;
    end

    // R3: end of the offset hands over to a window start
    p_delay_to_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_DELAY && st_q.dly >= dly_last && !slot_wrap) |=> integ_start);

    // R4: done is a single pulse when windows are longer than one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_done && len_last != '0) |=> (!integ_done || len_last == '0));

    // R5: the next window follows immediately
    p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_done && st_q.num < num_last && !slot_wrap) |=> integ_start);

    // R6: silence after the last window
    p_idle_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_done && st_q.num >= num_last && !slot_wrap) |=> !integ_active);

    // R7: a slot boundary or sync restarts the offset with the window closed
    p_wrap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wrap |=> (!integ_active && st_q.ph == PH_DELAY && st_q.dly == '0));
endmodule

// File: rtl/tsis_sequencer.sv
module tsis_sequencer #(
    parameter int CNT_W = 16,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] slot_len,
    input  logic [CNT_W-1:0] start_dly,
    input  logic [CNT_W-1:0] integ_len,
    input  logic [NUM_W-1:0] integ_count,
    output logic             slot_start,
    output logic             integ_active,
    output logic             integ_start,
    output logic             integ_done
);
    logic [CNT_W-1:0] slot_last, dly_last, len_last;
    logic [NUM_W-1:0] num_last;
    logic             slot_wrap;

    tsis_last_idx #(.W(CNT_W)) u_slot_idx (.val(slot_len),    .last(slot_last));
    tsis_last_idx #(.W(CNT_W)) u_dly_idx  (.val(start_dly),   .last(dly_last));
    tsis_last_idx #(.W(CNT_W)) u_len_idx  (.val(integ_len),   .last(len_last));
    tsis_last_idx #(.W(NUM_W)) u_num_idx  (.val(integ_count), .last(num_last));

    tsis_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_en    (sync_en),
        .sync_in    (sync_in),
        .slot_last  (slot_last),
        .slot_start (slot_start),
        .slot_wrap  (slot_wrap)
    );

    tsis_integ_seq #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_wrap    (slot_wrap),
        .dly_last     (dly_last),
        .len_last     (len_last),
        .num_last     (num_last),
        .integ_active (integ_active),
        .integ_start  (integ_start),
        .integ_done   (integ_done)
    );

    // R8: a window never stays open across a slot start
    p_slot_clears_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> !integ_active);
endmodule

// File: tb/tsis_sequencer_tb.sv
module tsis_sequencer_tb;
    localparam int CNT_W = 16;
    localparam int NUM_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_en = 1'b0;
    logic             sync_in = 1'b0;
    logic [CNT_W-1:0] slot_len = '0;
    logic [CNT_W-1:0] start_dly = '0;
    logic [CNT_W-1:0] integ_len = '0;
    logic [NUM_W-1:0] integ_count = '0;
    logic             slot_start, integ_active, integ_start, integ_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tsis_sequencer #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .sync_in(sync_in),
        .slot_len(slot_len), .start_dly(start_dly), .integ_len(integ_len),
        .integ_count(integ_count), .slot_start(slot_start),
        .integ_active(integ_active), .integ_start(integ_start),
        .integ_done(integ_done)
    );

    // Columns: S, D, L, N (raw), expected active cycles per slot, expected dones per slot
    localparam int NVEC = 10;
    localparam int VEC [NVEC][6] = '{
        '{10, 2, 3, 2,  6, 2},
        '{12, 1, 2, 5, 10, 5},
        '{ 8, 3, 4, 3,  5, 1},
        '{ 6, 0, 0, 0,  1, 1},
        '{ 1, 1, 1, 1,  0, 0},
        '{ 5, 7, 2, 2,  0, 0},
        '{20, 4, 1, 4,  4, 4},
        '{16, 2, 5, 1,  5, 1},
        '{ 9, 0, 3, 0,  3, 1},
        '{ 0, 0, 0, 0,  0, 0}
    };

    function automatic int nz(int x);
        return (x == 0) ? 1 : x;
    endfunction

    // Expected {slot_start, active, start, done} at slot position p
    function automatic logic [3:0] model(int p, int s, int d, int l, int n);
        logic act, st, dn;
        act = (p >= d) && (p < d + n * l) && (p < s);
        st  = act && (((p - d) % l) == 0);
        dn  = act && (((p - d) % l) == l - 1);
        return {p == 0, act, st, dn};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs();
        return {slot_start, integ_active, integ_start, integ_done};
    endfunction

    task automatic apply_reset(int s, int d, int l, int n);
        @(negedge clk);
        rst_n = 1'b0;
        slot_len = CNT_W'(s); start_dly = CNT_W'(d);
        integ_len = CNT_W'(l); integ_count = NUM_W'(n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        slot_len = 16'd10; start_dly = 16'd2; integ_len = 16'd3; integ_count = 8'd2;
        repeat (2) @(negedge clk);
        check("R9 reset outputs", 32'(outs()), 32'b1000);

        // Table walk: R1 R3 R4 R5 R6 R8 R9(zero as one)
        for (int v = 0; v < NVEC; v++) begin
            int s, d, l, n, acts, dones;
            s = nz(VEC[v][0]); d = nz(VEC[v][1]);
            l = nz(VEC[v][2]); n = nz(VEC[v][3]);
            acts = 0; dones = 0;
            apply_reset(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            for (int c = 0; c < 3 * s; c++) begin
                check("R1/R3/R4/R5/R6/R8 position model", 32'(outs()),
                      32'(model(c % s, s, d, l, n)));
                if (c < s) begin
                    acts  += int'(integ_active);
                    dones += int'(integ_done);
                end
                @(negedge clk);
            end
            check("R4 active cycles per slot", 32'(acts), 32'(VEC[v][4]));
            check("R5 dones per slot", 32'(dones), 32'(VEC[v][5]));
        end

        // R2 R7: accepted sync in the middle of a window
        apply_reset(20, 2, 4, 3);
        for (int c = 0; c < 7; c++) @(negedge clk);
        check("R7 window open before sync", 32'(outs()), 32'(model(7, 20, 2, 4, 3)));
        sync_en = 1'b1; sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        check("R2 sync realigns to slot start", 32'(outs()), 32'b1000);
        for (int c = 1; c < 20; c++) begin
            @(negedge clk);
            check("R7 delay restarts after sync", 32'(outs()), 32'(model(c, 20, 2, 4, 3)));
        end

        // R2: sync ignored while disabled
        apply_reset(20, 2, 4, 3);
        sync_en = 1'b0;
        for (int c = 0; c < 7; c++) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        check("R2 disabled sync ignored", 32'(outs()), 32'(model(8, 20, 2, 4, 3)));
        for (int c = 9; c < 24; c++) begin
            @(negedge clk);
            check("R2 disabled sync keeps timing", 32'(outs()), 32'(model(c % 20, 20, 2, 4, 3)));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule